// File: doc/BRIEF.md
# Instruction-Fetch Breakpoint Unit

This block watches the stream of instructions that an in-order pipeline has committed to execute. It raises a debug break request when an instruction address matches one of two independently configured channels. Each channel holds a compare address, an enable, a selector that restricts it to instruction fetches, and a choice of breaking before or after the matched instruction. Instructions that are fetched ahead and then discarded never reach the commit interface, so they can never cause a break.

Delayed branches get special handling. In before-mode, a hit on a delay slot is reported at the address of the branch that owns the slot. In after-mode, a hit on a taken delayed branch or on its slot is held back until the first instruction at the branch target. A delay-slot indication is honoured only when the previous committed instruction was a taken delayed branch.

Each break is a registered one-cycle pulse. It carries the address at which the break takes effect and a vector showing which channels caused it. Each channel also keeps a sticky match flag, which software clears by writing 0.

Top module: `ifbrk_unit`

## Requirements
- R1: A channel can only break when its enable is 1 and its fetch selector is 1. Clearing either one suppresses every break from that channel and discards any break it still has deferred.
- R2: Address comparison ignores bit 0 of the committed instruction address. A channel whose compare address has bit 0 set never breaks.
- R3: Only cycles with `cm_valid` = 1 are examined. A matching address presented with `cm_valid` = 0 causes no break.
- R4: Before-mode (`ch_post` bit = 0) on an ordinary instruction: `brk_req` pulses in the cycle after the commit beat, and `brk_pc` equals that instruction's address.
- R5: Before-mode on an effective delay slot: `brk_pc` equals the address of the preceding delayed branch, and the pulse comes one cycle after the slot's beat.
- R6: After-mode (`ch_post` bit = 1) on an ordinary instruction: the pulse follows the next committed instruction's beat, and `brk_pc` equals that next instruction's address.
- R7: After-mode on a taken delayed branch or on its effective delay slot: the break waits for the first committed instruction that is not an effective slot (the branch target), and `brk_pc` equals that target address.
- R8: `cm_slot` is honoured only when the previous committed instruction had `cm_dbranch` = 1 and `cm_taken` = 1. Otherwise the instruction is treated as ordinary.
- R9: Each triggering commit beat produces one single-cycle `brk_req`. If both channels trigger on the same beat, a single pulse is issued and `brk_hit` has both bits set (bit 0 = channel A, bit 1 = channel B).
- R10: A channel's bit in `flags` is set together with its break and then stays set. A strobe on `flag_wr` with `flag_wdata` = 0 clears it, and `flag_wdata` = 1 leaves it unchanged. If a channel is cleared and breaks in the same cycle, the flag stays set.
- R11: Synchronous reset forces `brk_req`, `brk_hit` and `flags` to 0 and drops all deferred breaks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_addr | input | NCH*AW | Compare addresses; channel i in bits [i*AW +: AW] |
| ch_en | input | NCH | Per-channel enable |
| ch_ifetch | input | NCH | Per-channel instruction-fetch selector |
| ch_post | input | NCH | Per-channel timing: 0 before, 1 after execution |
| cm_valid | input | 1 | A committed instruction is presented this cycle |
| cm_addr | input | AW | Address of the committed instruction |
| cm_dbranch | input | 1 | The instruction is a delayed branch |
| cm_taken | input | 1 | The delayed branch is taken |
| cm_slot | input | 1 | The instruction is presented as a delay slot |
| flag_wr | input | NCH | Per-channel flag write strobe |
| flag_wdata | input | NCH | Flag write data (0 clears) |
| brk_req | output | 1 | One-cycle break request |
| brk_pc | output | AW | Address at which the break takes effect |
| brk_hit | output | NCH | Channels that caused the current request |
| flags | output | NCH | Sticky per-channel match flags |

## Verification
Two things can coincide in one cycle. A channel can fire while software writes 0 to its flag. Separately, a deferred after-mode break from one channel can land on the same beat as a before-mode hit from the other. The bench provokes the first by strobing a clear on the exact beat that re-matches channel A, and expects the flag to survive; the same clear on a non-matching beat must empty the flag. The second arises in the sweep, where both compare addresses walk every instruction of straight-line, taken-branch and untaken-branch programs under all four mode pairs. There the bench expects exactly one pulse, both hit bits and a common break address.

// File: rtl/ifbrk_pkg.sv
package ifbrk_pkg;
  // When a channel's break takes effect relative to the matched instruction.
  typedef enum logic {
    WHEN_PRE  = 1'b0,
    WHEN_POST = 1'b1
  } brk_when_e;

  // Per-channel decision for the current commit beat.
  typedef struct packed {
    logic fire;
    logic at_branch;
  } chan_dec_t;
endpackage

// File: rtl/ifbrk_slot_track.sv
// Remembers the previous committed instruction so that a delay-slot marker
// is honoured only behind a taken delayed branch.
module ifbrk_slot_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cm_valid,
  input  logic [AW-1:0] cm_addr,
  input  logic          cm_dbranch,
  input  logic          cm_taken,
  input  logic          cm_slot,
  output logic          eff_slot,
  output logic [AW-1:0] prev_addr
);
  logic taken_db_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_db_q <= 1'b0;
      prev_addr  <= '0;
    end else if (cm_valid) begin
      taken_db_q <= cm_dbranch & cm_taken;
      prev_addr  <= cm_addr;
    end
  end

  assign eff_slot = cm_valid & cm_slot & taken_db_q;
endmodule

// File: rtl/ifbrk_chan.sv
// One breakpoint channel: address compare plus deferral for after-mode.
module ifbrk_chan
  import ifbrk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cfg_addr,
  input  logic          cfg_en,
  input  logic          cfg_ifetch,
  input  brk_when_e     cfg_when,
  input  logic          cm_valid,
  input  logic [AW-1:0] cm_addr,
  input  logic          eff_slot,
  output chan_dec_t     dec
);
  localparam logic [AW-1:0] CMP_MASK = {{(AW-1){1'b1}}, 1'b0};

  logic armed;
  logic addr_hit;
  logic pre_fire;
  logic post_fire;
  logic pend_q;

  assign armed     = cfg_en & cfg_ifetch & ~cfg_addr[0];
  assign addr_hit  = cm_valid & armed & (((cm_addr ^ cfg_addr) & CMP_MASK) == '0);
  assign pre_fire  = addr_hit & (cfg_when == WHEN_PRE);
  assign post_fire = armed & (cfg_when == WHEN_POST) & pend_q & cm_valid & ~eff_slot;

  always_comb begin
    dec.fire      = pre_fire | post_fire;
    dec.at_branch = pre_fire & eff_slot;
  end

  // Deferred after-mode break: held across an effective slot, re-armed by a hit.
  always_ff @(posedge clk) begin
    if (rst || !armed || cfg_when != WHEN_POST) begin
      pend_q <= 1'b0;
    end else if (cm_valid) begin
      pend_q <= (pend_q & eff_slot) | addr_hit;
    end
  end
endmodule

// File: rtl/ifbrk_flags.sv
// Sticky per-channel match flags; a set in the same cycle beats a clear.
module ifbrk_flags #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set,
  input  logic [NCH-1:0] wr,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] flags
);
  for (genvar i = 0; i < NCH; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (wr[i] && !wdata[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ifbrk_unit.sv
module ifbrk_unit
  import ifbrk_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH*AW-1:0]  ch_addr,
  input  logic [NCH-1:0]     ch_en,
  input  logic [NCH-1:0]     ch_ifetch,
  input  logic [NCH-1:0]     ch_post,
  input  logic               cm_valid,
  input  logic [AW-1:0]      cm_addr,
  input  logic               cm_dbranch,
  input  logic               cm_taken,
  input  logic               cm_slot,
  input  logic [NCH-1:0]     flag_wr,
  input  logic [NCH-1:0]     flag_wdata,
  output logic               brk_req,
  output logic [AW-1:0]      brk_pc,
  output logic [NCH-1:0]     brk_hit,
  output logic [NCH-1:0]     flags
);
  logic            eff_slot;
  logic [AW-1:0]   prev_addr;
  chan_dec_t       dec [NCH];
  logic [NCH-1:0]  fire_v;
  logic [NCH-1:0]  at_branch_v;

  ifbrk_slot_track #(.AW(AW)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .cm_valid   (cm_valid),
    .cm_addr    (cm_addr),
    .cm_dbranch (cm_dbranch),
    .cm_taken   (cm_taken),
    .cm_slot    (cm_slot),
    .eff_slot   (eff_slot),
    .prev_addr  (prev_addr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ifbrk_chan #(.AW(AW)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .cfg_addr   (ch_addr[i*AW +: AW]),
      .cfg_en     (ch_en[i]),
      .cfg_ifetch (ch_ifetch[i]),
      .cfg_when   (brk_when_e'(ch_post[i])),
      .cm_valid   (cm_valid),
      .cm_addr    (cm_addr),
      .eff_slot   (eff_slot),
      .dec        (dec[i])
    );
    assign fire_v[i]      = dec[i].fire;
    assign at_branch_v[i] = dec[i].at_branch;
  end

  ifbrk_flags #(.NCH(NCH)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   (fire_v),
    .wr    (flag_wr),
    .wdata (flag_wdata),
    .flags (flags)
  );

  // Registered request: one pulse per triggering beat, merged across channels.
  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req <= 1'b0;
      brk_hit <= '0;
      brk_pc  <= '0;
    end else begin
      brk_req <= |fire_v;
      brk_hit <= fire_v;
      if (|fire_v) brk_pc <= (|at_branch_v) ? prev_addr : cm_addr;
    end
  end
endmodule

// File: rtl/ifbrk_unit_chk.sv
module ifbrk_unit_chk #(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NCH*AW-1:0]  ch_addr,
  input logic [NCH-1:0]     ch_en,
  input logic [NCH-1:0]     ch_ifetch,
  input logic [NCH-1:0]     ch_post,
  input logic               cm_valid,
  input logic [AW-1:0]      cm_addr,
  input logic               cm_dbranch,
  input logic               cm_taken,
  input logic               cm_slot,
  input logic [NCH-1:0]     flag_wr,
  input logic [NCH-1:0]     flag_wdata,
  input logic               brk_req,
  input logic [AW-1:0]      brk_pc,
  input logic [NCH-1:0]     brk_hit,
  input logic [NCH-1:0]     flags
);
  localparam logic [AW-1:0] CMP_MASK = {{(AW-1){1'b1}}, 1'b0};

  // R11: reset clears the request and the flags
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!brk_req && flags == '0));

  // R3: a cycle without a committed instruction never triggers a request
  a_r3_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !cm_valid |=> !brk_req);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R1: disabled or non-fetch channel never contributes
    a_r1_off_no_hit: assert property (@(posedge clk) disable iff (rst)
      !(ch_en[i] && ch_ifetch[i]) |=> !brk_hit[i]);

    // R2: odd compare address never contributes
    a_r2_odd_no_hit: assert property (@(posedge clk) disable iff (rst)
      ch_addr[i*AW] |=> !brk_hit[i]);

    // R4: before-mode hit raises a request naming the channel next cycle
    a_r4_pre_hit: assert property (@(posedge clk) disable iff (rst)
      (cm_valid && ch_en[i] && ch_ifetch[i] && !ch_post[i] && !ch_addr[i*AW]
       && (((cm_addr ^ ch_addr[i*AW +: AW]) & CMP_MASK) == '0))
      |=> (brk_req && brk_hit[i]));

    // R10: a set flag survives unless cleared by a write of 0
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !(flag_wr[i] && !flag_wdata[i])) |=> flags[i]);
  end
endmodule

bind ifbrk_unit ifbrk_unit_chk #(.NCH(NCH), .AW(AW)) u_chk (.*);

// File: tb/ifbrk_unit_test.sv
`timescale 1ns/1ps
module ifbrk_unit_test;
  localparam int NCH = 2;
  localparam int AW  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH*AW-1:0] ch_addr = '0;
  logic [NCH-1:0]    ch_en = '0, ch_ifetch = '0, ch_post = '0;
  logic              cm_valid = 1'b0;
  logic [AW-1:0]     cm_addr = '0;
  logic              cm_dbranch = 1'b0, cm_taken = 1'b0, cm_slot = 1'b0;
  logic [NCH-1:0]    flag_wr = '0, flag_wdata = '0;
  logic              brk_req;
  logic [AW-1:0]     brk_pc;
  logic [NCH-1:0]    brk_hit, flags;

  always #2.5 clk = ~clk;

  ifbrk_unit #(.NCH(NCH), .AW(AW)) uut (.*);

  int n_cmp = 0, n_bad = 0;

  // Expected-behaviour state, derived from the requirements.
  logic [NCH-1:0] m_pend = '0;
  logic           m_tdb = 1'b0;
  logic [AW-1:0]  m_prev = '0;
  logic           e_req = 1'b0;
  logic [AW-1:0]  e_pc = '0;
  logic [NCH-1:0] e_hit = '0, e_flags = '0;

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model();
    logic es, pslot;
    logic [NCH-1:0] f;
    es = cm_valid && cm_slot && m_tdb;      // R8
    f = '0; pslot = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      logic [AW-1:0] ca;
      logic cond, hit;
      ca   = ch_addr[c*AW +: AW];
      cond = ch_en[c] && ch_ifetch[c] && !ca[0];
      hit  = cm_valid && cond && ((cm_addr >> 1) == (ca >> 1));
      if (hit && !ch_post[c]) begin f[c] = 1'b1; if (es) pslot = 1'b1; end
      if (cond && ch_post[c] && m_pend[c] && cm_valid && !es) f[c] = 1'b1;
      if (!cond || !ch_post[c]) m_pend[c] = 1'b0;
      else if (cm_valid) m_pend[c] = (m_pend[c] && es) || hit;
    end
    if (rst) begin
      e_req = 0; e_hit = '0; e_flags = '0; m_pend = '0; m_tdb = 0; m_prev = '0;
    end else begin
      e_req = |f;
      e_hit = f;
      if (|f) e_pc = pslot ? m_prev : cm_addr;
      e_flags = (e_flags & ~(flag_wr & ~flag_wdata)) | f;
      if (cm_valid) begin m_tdb = cm_dbranch && cm_taken; m_prev = cm_addr; end
    end
  endtask

  // One clock: drive at a falling edge, check at the next falling edge.
  task automatic step(input string tag, input logic v, input logic [AW-1:0] a,
                      input logic db, input logic tk, input logic sl);
    cm_valid = v; cm_addr = a; cm_dbranch = db; cm_taken = tk; cm_slot = sl;
    model();
    @(negedge clk);
    chk({tag, " brk_req"}, AW'(brk_req), AW'(e_req));
    if (e_req) chk({tag, " brk_pc"}, brk_pc, e_pc);
    chk({tag, " R9 brk_hit"}, AW'(brk_hit), AW'(e_hit));
    chk({tag, " R10 flags"}, AW'(flags), AW'(e_flags));
    flag_wr = '0; flag_wdata = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step("R11", 1'b0, '0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  function automatic logic [AW-1:0] pc_of(input int kind, input int k);
    if (k == 8) return 32'h0000_3000;
    if (kind == 1 && k >= 5) return 32'h0000_2000 + 32'(4 * (k - 5));
    return 32'h0000_1000 + 32'(4 * k);
  endfunction

  task automatic run_prog(input int kind, input bit gap, input string tag);
    for (int k = 0; k <= 8; k++) begin
      logic db, sl;
      db = (kind != 0) && (k == 3);
      sl = (kind != 0) && (k == 4);
      step(tag, 1'b1, pc_of(kind, k), db, kind == 1, sl);
      if (gap) step({tag, " R3"}, 1'b0, ch_addr[AW-1:0], 1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog R1..R11 act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    step("R11", 1'b0, '0, 1'b0, 1'b0, 1'b0);

    // Sweep: both channels walk every instruction of three program shapes.
    ch_en = '1; ch_ifetch = '1;
    for (int kind = 0; kind < 3; kind++)
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++)
          for (int m = 0; m < 4; m++)
            for (int g = 0; g < 2; g++) begin
              string tag;
              tag = (kind == 0) ? "R4 R6" : (kind == 1) ? "R5 R7" : "R8";
              if (i == j) tag = {tag, " R9"};
              ch_addr[0 +: AW]  = (i == 8) ? 32'h5000 : pc_of(kind, i);
              ch_addr[AW +: AW] = (j == 8) ? 32'h5000 : pc_of(kind, j);
              ch_post = NCH'(m);
              do_reset();
              run_prog(kind, g[0], tag);
            end

    // R1: disabled channel and data-side channel stay silent.
    ch_post = '0;
    ch_addr[0 +: AW] = 32'h1000; ch_addr[AW +: AW] = 32'h1000;
    ch_en = 2'b10; ch_ifetch = 2'b01;
    do_reset();
    step("R1", 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0);
    step("R1", 1'b1, 32'h1004, 1'b0, 1'b0, 1'b0);

    // R2: odd compare address disabled; odd instruction address still matches.
    ch_en = '1; ch_ifetch = '1;
    ch_addr[0 +: AW] = 32'h1001; ch_addr[AW +: AW] = 32'h1008;
    step("R2", 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0);
    step("R2", 1'b1, 32'h1001, 1'b0, 1'b0, 1'b0);
    step("R2", 1'b1, 32'h1009, 1'b0, 1'b0, 1'b0);

    // R1: disabling an after-mode channel drops its deferred break.
    ch_post = 2'b01; ch_addr[0 +: AW] = 32'h1000;
    do_reset();
    step("R1 R6", 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0);
    ch_en = 2'b10;
    step("R1", 1'b1, 32'h1004, 1'b0, 1'b0, 1'b0);
    ch_en = '1;
    step("R1", 1'b1, 32'h1008, 1'b0, 1'b0, 1'b0);

    // R10: clear and set in the same cycle, plain clear, write of 1.
    ch_post = '0;
    ch_addr[0 +: AW] = 32'h1000; ch_addr[AW +: AW] = 32'h1004;
    do_reset();
    step("R10", 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0);
    flag_wr = 2'b01; flag_wdata = 2'b00;
    step("R10 same-cycle", 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0);
    flag_wr = 2'b01; flag_wdata = 2'b00;
    step("R10 clear", 1'b1, 32'h1008, 1'b0, 1'b0, 1'b0);
    step("R10", 1'b1, 32'h1004, 1'b0, 1'b0, 1'b0);
    flag_wr = 2'b10; flag_wdata = 2'b11;
    step("R10 write1", 1'b0, '0, 1'b0, 1'b0, 1'b0);
    flag_wr = 2'b10; flag_wdata = 2'b00;
    step("R10 clear", 1'b0, '0, 1'b0, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule